// File: doc/BRIEF.md
# Nested Walk Entry Cache

This block is a small, fully associative store of page table entries for a two-dimensional (guest and nested) page walker. Before the walker issues a memory read for an entry, it probes the store with the system physical address where that entry lives. On a hit, the entry arrives one cycle later and the memory read is skipped. On a miss, the walker reads memory as it normally would. It then offers the entry for fill, together with its walk dimension and table level. The store only ever replaces memory reads. A walk's result is the same whether it hits or misses.

Every entry is tagged by its own system physical address, whichever dimension it belongs to. A fixed admission rule keeps lowest-level guest entries out, since they are rarely reused. Lowest-level nested entries are also refused unless a build parameter allows them. Replacement is true least-recently-used across all slots. A single flush input empties the whole store, which keeps it coherent after page tables are rewritten. Two counters expose the number of hits and misses.

Top module: `nested_walk_cache`

## Requirements
- R1: A probe asserted in one cycle produces `respValid` high in the next cycle. On a hit, `respHit` is 1 and `respData` holds the stored entry. On a miss, `respHit` is 0 and `respData` is zero.
- R2: Matching uses address bits from bit 3 upward. The three lowest address bits are ignored, so addresses that differ only in bits 2:0 name the same entry.
- R3: A fill at level code 1, 2 or 3 (`fillLevel` holds the table level minus one) is admitted from either dimension. A probe in the cycle after the fill hits and returns the filled data.
- R4: A guest fill (`fillNested` = 0) with level code 0, which is table level 1, is never stored. A later probe of its address misses.
- R5: With the default `CACHE_NESTED_L1` = 0, a nested fill (`fillNested` = 1) with level code 0 is also refused.
- R6: A fill to an address already held overwrites that slot's data in place and takes no second slot.
- R7: An admitted fill goes to the lowest-numbered empty slot. When no slot is empty, it evicts the least recently used entry. Both hits and fills make an entry the most recently used.
- R8: Asserting `flush` for one cycle empties every slot from the next cycle on. A probe in the flush cycle itself still sees the old contents.
- R9: A fill offered in the same cycle as `flush` is dropped.
- R10: `hitCount` and `missCount` each advance by one in the cycle that a hit or miss response appears, and both are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Probe request |
| lookupAddr | input | ADDR_W | System physical address of the probed entry |
| fillValid | input | 1 | Fill offer |
| fillAddr | input | ADDR_W | System physical address of the offered entry |
| fillData | input | DATA_W | Offered entry contents |
| fillNested | input | 1 | 1 = nested dimension, 0 = guest dimension |
| fillLevel | input | LVL_W | Table level minus one (0 = level 1) |
| flush | input | 1 | Invalidate all slots |
| respValid | output | 1 | Response for the probe of the previous cycle |
| respHit | output | 1 | Probe hit |
| respData | output | DATA_W | Entry on hit, zero on miss |
| hitCount | output | CNT_W | Number of hits since reset |
| missCount | output | CNT_W | Number of misses since reset |

## Verification
Probes are driven at exact addresses, at offsets inside the same 8-byte entry, and at the neighbouring entry. This separates a correct tag slice from one that is too wide or too narrow. Fills are offered at every level and in both dimensions, so that admission mistakes show up as hits where misses are expected. A repeated fill to one address, followed by enough fills to fill every slot, shows whether a duplicate slot was taken. A full store, one refreshing hit and one extra fill pin down which entry is evicted. Probes issued in the flush cycle and just after it, plus a fill issued together with a flush, test the ordering rules at the flush boundary.

// File: rtl/nwc_pkg.sv
package nwc_pkg;
  // Strobes from the control half to the storage half
  typedef struct packed {
    logic capture;      // a probe is being answered this cycle
    logic touchHit;     // refresh recency of the probe's matching slot
    logic writeNew;     // admit a fill into a fresh or evicted slot
    logic writeUpdate;  // overwrite the slot already holding the fill address
    logic flush;        // empty every slot
  } nwc_strobe_t;
endpackage

// File: rtl/nwc_store.sv
module nwc_store
  import nwc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 52,
  parameter int DATA_W  = 64,
  parameter int OFF_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  nwc_strobe_t       strobe,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  output logic              lookupHit,
  output logic              fillHit,
  output logic [DATA_W-1:0] respData
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [TAG_W-1:0]  tagQ  [ENTRIES];
  logic [DATA_W-1:0] dataQ [ENTRIES];
  logic [IDX_W-1:0]  ageQ  [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] lookMatch, fillMatch;
  logic [TAG_W-1:0]  lookTag, fillTag;
  logic [IDX_W-1:0]  hitIdx, fillIdx, freeIdx, oldIdx, victimIdx, writeIdx, touchIdx;
  logic              anyFree, writeEn, touchEn;

  assign lookTag = lookupAddr[ADDR_W-1:OFF_W];
  assign fillTag = fillAddr[ADDR_W-1:OFF_W];

  // One comparator pair per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign lookMatch[g] = validQ[g] && (tagQ[g] == lookTag);
    assign fillMatch[g] = validQ[g] && (tagQ[g] == fillTag);
  end

  assign lookupHit = |lookMatch;
  assign fillHit   = |fillMatch;

  // Priority encoders: lowest index wins
  always_comb begin
    hitIdx  = '0;
    fillIdx = '0;
    freeIdx = '0;
    oldIdx  = '0;
    anyFree = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lookMatch[i]) hitIdx = IDX_W'(i);
      if (fillMatch[i]) fillIdx = IDX_W'(i);
      if (!validQ[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
      if (ageQ[i] == OLDEST) oldIdx = IDX_W'(i);
    end
  end

  assign victimIdx = anyFree ? freeIdx : oldIdx;
  assign writeEn   = strobe.writeNew || strobe.writeUpdate;
  assign writeIdx  = strobe.writeUpdate ? fillIdx : victimIdx;
  assign touchEn   = writeEn || strobe.touchHit;
  assign touchIdx  = writeEn ? writeIdx : hitIdx;

  // Valid bits and recency ranks; ranks always form a permutation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) ageQ[i] <= IDX_W'(i);
    end else if (strobe.flush) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) ageQ[i] <= IDX_W'(i);
    end else begin
      if (writeEn) validQ[writeIdx] <= 1'b1;
      if (touchEn) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == touchIdx) ageQ[i] <= '0;
          else if (ageQ[i] < ageQ[touchIdx]) ageQ[i] <= ageQ[i] + 1'b1;
        end
      end
    end
  end

  // Tag and data storage, no reset needed
  always_ff @(posedge clk) begin
    if (writeEn && !strobe.flush) begin
      tagQ[writeIdx]  <= fillTag;
      dataQ[writeIdx] <= fillData;
    end
  end

  // Response data register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respData <= '0;
    else if (strobe.capture && lookupHit) respData <= dataQ[hitIdx];
    else respData <= '0;
  end
endmodule

// File: rtl/nwc_ctrl.sv
module nwc_ctrl
  import nwc_pkg::*;
#(
  parameter int LVL_W           = 2,
  parameter int CNT_W           = 32,
  parameter bit CACHE_NESTED_L1 = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             fillValid,
  input  logic             fillNested,
  input  logic [LVL_W-1:0] fillLevel,
  input  logic             flush,
  input  logic             lookupHit,
  input  logic             fillHit,
  output nwc_strobe_t      strobe,
  output logic             respValid,
  output logic             respHit,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);
  logic lowestLevel, refused, admit;

  // Admission rule: level 1 guest entries never, level 1 nested per parameter
  assign lowestLevel = (fillLevel == '0);
  assign refused     = lowestLevel && (!fillNested || !CACHE_NESTED_L1);
  assign admit       = fillValid && !flush && !refused;

  always_comb begin
    strobe.flush       = flush;
    strobe.capture     = lookupValid;
    strobe.writeUpdate = admit && fillHit;
    strobe.writeNew    = admit && !fillHit;
    // a fill in the same cycle owns the recency update
    strobe.touchHit    = lookupValid && lookupHit && !admit && !flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      respValid <= lookupValid;
      respHit   <= lookupValid && lookupHit;
      if (lookupValid) begin
        if (lookupHit) hitCount <= hitCount + 1'b1;
        else missCount <= missCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nested_walk_cache.sv
module nested_walk_cache
  import nwc_pkg::*;
#(
  parameter int ENTRIES         = 16,
  parameter int ADDR_W          = 52,
  parameter int DATA_W          = 64,
  parameter int LVL_W           = 2,
  parameter int CNT_W           = 32,
  parameter bit CACHE_NESTED_L1 = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  input  logic              fillNested,
  input  logic [LVL_W-1:0]  fillLevel,
  input  logic              flush,
  output logic              respValid,
  output logic              respHit,
  output logic [DATA_W-1:0] respData,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);
  localparam int OFF_W = 3;  // entries are 8 bytes

  nwc_strobe_t strobe;
  logic lookupHit, fillHit;

  nwc_ctrl #(
    .LVL_W(LVL_W), .CNT_W(CNT_W), .CACHE_NESTED_L1(CACHE_NESTED_L1)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .fillValid(fillValid),
    .fillNested(fillNested), .fillLevel(fillLevel), .flush(flush),
    .lookupHit(lookupHit), .fillHit(fillHit), .strobe(strobe),
    .respValid(respValid), .respHit(respHit),
    .hitCount(hitCount), .missCount(missCount)
  );

  nwc_store #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lookupAddr(lookupAddr),
    .fillAddr(fillAddr), .fillData(fillData), .lookupHit(lookupHit),
    .fillHit(fillHit), .respData(respData)
  );
endmodule

// File: rtl/nwc_checker.sv
module nwc_checker #(
  parameter int ADDR_W = 52,
  parameter int DATA_W = 64,
  parameter int LVL_W  = 2,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic [ADDR_W-1:0] lookupAddr,
  input logic              fillValid,
  input logic [ADDR_W-1:0] fillAddr,
  input logic [DATA_W-1:0] fillData,
  input logic [LVL_W-1:0]  fillLevel,
  input logic              flush,
  input logic              respValid,
  input logic              respHit,
  input logic [DATA_W-1:0] respData,
  input logic [CNT_W-1:0]  hitCount,
  input logic [CNT_W-1:0]  missCount
);
  assert_miss_data_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respData == '0));

  assert_fill_visible_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && (fillLevel != '0) && !flush) ##1
    (lookupValid && (lookupAddr[ADDR_W-1:3] == $past(fillAddr[ADDR_W-1:3])))
    |=> (respHit && (respData == $past(fillData, 2))));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush ##1 lookupValid |=> !respHit);

  assert_flush_drops_fill_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flush && fillValid) ##1
    (lookupValid && (lookupAddr[ADDR_W-1:3] == $past(fillAddr[ADDR_W-1:3])))
    |=> !respHit);

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (CNT_W'(hitCount + missCount) ==
                   CNT_W'($past(hitCount) + $past(missCount) + 1'b1)));

  assert_count_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> ($stable(hitCount) && $stable(missCount)));
endmodule

bind nested_walk_cache nwc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
  .fillValid(fillValid), .fillAddr(fillAddr), .fillData(fillData),
  .fillLevel(fillLevel), .flush(flush), .respValid(respValid),
  .respHit(respHit), .respData(respData), .hitCount(hitCount),
  .missCount(missCount)
);

// File: tb/nested_walk_cache_tb.sv
`timescale 1ns/1ps
module nested_walk_cache_tb;
  localparam int ADDR_W = 52;
  localparam int DATA_W = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [ADDR_W-1:0] lookupAddr = '0;
  logic fillValid = 1'b0;
  logic [ADDR_W-1:0] fillAddr = '0;
  logic [DATA_W-1:0] fillData = '0;
  logic fillNested = 1'b0;
  logic [1:0] fillLevel = '0;
  logic flush = 1'b0;
  logic respValid, respHit;
  logic [DATA_W-1:0] respData;
  logic [31:0] hitCount, missCount;

  int checks = 0;
  int fails = 0;
  int expHits = 0;
  int expMisses = 0;

  always #4 clk = ~clk;  // 125 MHz

  nested_walk_cache u_dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillData(fillData),
    .fillNested(fillNested), .fillLevel(fillLevel), .flush(flush),
    .respValid(respValid), .respHit(respHit), .respData(respData),
    .hitCount(hitCount), .missCount(missCount)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Offer a fill for one cycle
  task automatic doFill(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input bit nested, input logic [1:0] lvl, input bit withFlush);
    @(negedge clk);
    fillValid = 1'b1; fillAddr = a; fillData = d;
    fillNested = nested; fillLevel = lvl; flush = withFlush;
    @(negedge clk);
    fillValid = 1'b0; flush = 1'b0;
  endtask

  // Probe one address; compare response and counters
  task automatic probe(input logic [ADDR_W-1:0] a, input bit expHit,
                       input logic [DATA_W-1:0] expData, input bit withFlush,
                       input string req);
    @(negedge clk);
    lookupValid = 1'b1; lookupAddr = a; flush = withFlush;
    @(negedge clk);
    lookupValid = 1'b0; flush = 1'b0;
    if (expHit) expHits++; else expMisses++;
    check(respValid === 1'b1, req, 64'(respValid), 64'd1);
    check(respHit === expHit, req, 64'(respHit), 64'(expHit));
    check(respData === (expHit ? expData : '0), req, respData, expHit ? expData : '0);
    check(hitCount == 32'(expHits) && missCount == 32'(expMisses), "R10",
          {hitCount, missCount}, {32'(expHits), 32'(expMisses)});
  endtask

  task automatic doFlush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] slotAddr(input int k);
    return ADDR_W'(64'h4000_0000 + 64'(k) * 64'h1000);
  endfunction

  task automatic testReset();
    check(respValid === 1'b0, "R1 reset", 64'(respValid), 0);
    check(hitCount == 0 && missCount == 0, "R10 reset", {hitCount, missCount}, 0);
    probe(ADDR_W'(64'h1234_5000), 1'b0, '0, 1'b0, "R1 empty miss");
  endtask

  task automatic testBasic();
    doFill(ADDR_W'(64'h10_0040), 64'hAAAA_0004, 1'b0, 2'd3, 1'b0);
    probe(ADDR_W'(64'h10_0040), 1'b1, 64'hAAAA_0004, 1'b0, "R3 guest L4 hit");
    probe(ADDR_W'(64'h10_0045), 1'b1, 64'hAAAA_0004, 1'b0, "R2 low bits ignored");
    probe(ADDR_W'(64'h10_0048), 1'b0, '0, 1'b0, "R2 next entry misses");
    doFill(ADDR_W'(64'h20_0100), 64'hBBBB_0002, 1'b1, 2'd1, 1'b0);
    probe(ADDR_W'(64'h20_0100), 1'b1, 64'hBBBB_0002, 1'b0, "R3 nested L2 hit");
  endtask

  task automatic testRefuse();
    doFill(ADDR_W'(64'h30_0008), 64'hCCCC_0001, 1'b0, 2'd0, 1'b0);
    probe(ADDR_W'(64'h30_0008), 1'b0, '0, 1'b0, "R4 guest L1 refused");
    doFill(ADDR_W'(64'h30_0010), 64'hCCCC_0011, 1'b1, 2'd0, 1'b0);
    probe(ADDR_W'(64'h30_0010), 1'b0, '0, 1'b0, "R5 nested L1 refused");
  endtask

  task automatic testUpdate();
    doFlush();
    doFill(ADDR_W'(64'h50_0000), 64'hD1, 1'b0, 2'd2, 1'b0);
    doFill(ADDR_W'(64'h50_0000), 64'hD2, 1'b1, 2'd2, 1'b0);
    probe(ADDR_W'(64'h50_0000), 1'b1, 64'hD2, 1'b0, "R6 updated data");
    for (int k = 1; k < 16; k++) doFill(slotAddr(k), 64'(k) + 64'h700, 1'b0, 2'd1, 1'b0);
    probe(ADDR_W'(64'h50_0000), 1'b1, 64'hD2, 1'b0, "R6 single slot");
    for (int k = 1; k < 16; k++) probe(slotAddr(k), 1'b1, 64'(k) + 64'h700, 1'b0, "R6 others kept");
  endtask

  task automatic testLru();
    doFlush();
    for (int k = 0; k < 16; k++) doFill(slotAddr(k), 64'(k) + 64'h900, 1'b1, 2'd2, 1'b0);
    probe(slotAddr(0), 1'b1, 64'h900, 1'b0, "R7 refresh oldest");
    doFill(ADDR_W'(64'h77_0000), 64'hEE, 1'b0, 2'd3, 1'b0);
    probe(slotAddr(1), 1'b0, '0, 1'b0, "R7 LRU evicted");
    probe(slotAddr(0), 1'b1, 64'h900, 1'b0, "R7 refreshed kept");
    probe(ADDR_W'(64'h77_0000), 1'b1, 64'hEE, 1'b0, "R7 new entry");
    probe(slotAddr(15), 1'b1, 64'h90F, 1'b0, "R7 recent kept");
  endtask

  task automatic testFlush();
    doFill(ADDR_W'(64'h88_0000), 64'hF0, 1'b0, 2'd1, 1'b0);
    probe(ADDR_W'(64'h88_0000), 1'b1, 64'hF0, 1'b1, "R8 probe in flush cycle");
    probe(ADDR_W'(64'h88_0000), 1'b0, '0, 1'b0, "R8 after flush");
    probe(slotAddr(0), 1'b0, '0, 1'b0, "R8 all emptied");
    doFill(ADDR_W'(64'h99_0000), 64'hF1, 1'b0, 2'd2, 1'b1);
    probe(ADDR_W'(64'h99_0000), 1'b0, '0, 1'b0, "R9 fill with flush dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testRefuse();
    testUpdate();
    testLru();
    testFlush();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule